// File: doc/BRIEF.md
# Multi-Mode Trace Capture Buffer

This block is an on-chip trace sink. Trace words arrive on a valid/ready stream, each carrying a source identifier, and are written into a small internal RAM. The identifier is stored next to the data, so words from several sources can share one buffer and still be told apart later. Three behaviours are selected at run time through a control register on an APB-style register port. In circular capture, the newest trace overwrites the oldest. In hardware queue mode, the RAM sits in the stream path and smooths bursts toward a downstream valid/ready consumer. In software queue mode, software drains the RAM one word per read of a data register.

Back-pressure rules are as follows. On the input, a word transfers on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while capture is disabled. It is also low in either queue mode while the buffer is full. In circular mode it is high whenever capture is enabled. On the output, a word transfers on any edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the presented word stays unchanged. The register port has no wait states: read data is valid during the access phase, and any effect of the access lands on the edge that ends it.

Software enables capture, picks the mode and reads the status flags, the write pointer and the read pointer. Capture can be ended by software or by the `cap_stop` input. The pointers stay readable afterwards, so a circular capture can be unloaded from its oldest entry.

Top module: `trc_capture_buf`

## Requirements
- R1: In circular mode (mode code 0, or the unused code 3), `in_ready` is high for every cycle that capture is enabled. The write pointer steps from DEPTH-1 back to 0, and each new word replaces the oldest stored word.
- R2: In circular mode, STATUS bit 2 (wrapped) stays 0 until the first word is written at index DEPTH-1 and then stays 1 until capture is restarted. While capture is disabled in circular mode, software may write RPTR with a value below DEPTH. Each DATA read in circular mode returns the word at RPTR and advances RPTR by one, wrapping at DEPTH.
- R3: In hardware queue mode (code 1) and software queue mode (code 2), `in_ready` is low while DEPTH words are held, and no stored word is overwritten. STATUS bit 1 (full) reports this condition.
- R4: In hardware queue mode, `out_valid` is high exactly when the buffer holds a word. Words leave in arrival order. The presented word and source stay stable while `out_ready` is low.
- R5: In software queue mode, each DATA read that finds the buffer non-empty returns the oldest word and removes it.
- R6: A DATA read while the buffer is empty (STATUS bit 0 set) returns 32'hFFFF_FFFF and leaves RPTR unchanged. A DATA read in hardware queue mode also returns all-ones and has no effect.
- R7: A DATA read returns the source identifier in bits [31:24] and the trace data in bits [23:0]. The downstream port presents the same pair on `out_src` and `out_data`.
- R8: CTRL bit 0 is enable and bits [2:1] are the mode. A CTRL write changes the mode only while capture is disabled. While capture is enabled, the mode field of a CTRL write is ignored.
- R9: When `cap_stop` is high, a word accepted in that same cycle is still stored. From the next cycle on, CTRL bit 0 reads 0 and `in_ready` is low, while WPTR and RPTR keep their values.
- R10: A CTRL write that sets enable while capture is disabled clears both pointers, the word count and the wrapped flag.
- R11: While capture is disabled, `in_ready` is low in every mode.
- R12: Register word offsets are CTRL 0x00, STATUS 0x04, WPTR 0x08, RPTR 0x0C and DATA 0x10. Reads of any other address return 0. After reset, CTRL reads 0 and STATUS reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input trace word valid |
| in_ready | output | 1 | Buffer can take an input word |
| in_data | input | DATA_W | Input trace data |
| in_src | input | SRC_W | Source identifier of the input word |
| out_valid | output | 1 | Downstream word valid (hardware queue mode) |
| out_ready | input | 1 | Downstream consumer takes the word |
| out_data | output | DATA_W | Downstream trace data |
| out_src | output | SRC_W | Downstream source identifier |
| cap_stop | input | 1 | End capture after the current cycle |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Register port write strobe |
| paddr | input | 5 | Register byte address |
| pwdata | input | 32 | Register write data |
| prdata | output | 32 | Register read data |

## Verification
The results fall due at different times:

- **Same cycle.** `in_ready` reacts within the cycle to the enable flag, the mode and the word count. Register read data appears combinationally during the access phase.
- **One edge later.** A push, a pop, a CTRL write or a stop takes effect on the edge that ends the handshake or the access. A downstream word therefore appears one edge after it is accepted.

To keep to this timing, the bench drives every input one time unit after a rising edge and samples ready, valid and read data at the falling edge. It queues each accepted word at the moment of its handshake. A monitor then compares the head of that queue against every downstream transfer and every software-mode DATA read.

// File: rtl/trc_capture_pkg.sv
package trc_capture_pkg;
  typedef enum logic [1:0] {
    MODE_CIRC = 2'd0,
    MODE_HWQ  = 2'd1,
    MODE_SWQ  = 2'd2
  } cap_mode_e;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_STATUS = 1;
  localparam int unsigned REG_WPTR   = 2;
  localparam int unsigned REG_RPTR   = 3;
  localparam int unsigned REG_DATA   = 4;
endpackage

// File: rtl/trc_store.sv
module trc_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trc_ptr_ctrl.sv
module trc_ptr_ctrl
  import trc_capture_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          cap_stop,
  input  logic          wr_ctrl,
  input  logic          wr_rptr,
  input  logic          rd_data,
  input  logic [31:0]   wdata,
  output logic          en_q,
  output logic [1:0]    mode_q,
  output logic [AW-1:0] wptr_q,
  output logic [AW-1:0] rptr_q,
  output logic          wrapped_q,
  output logic          empty,
  output logic          full,
  output logic          is_hw,
  output logic          in_ready,
  output logic          push,
  output logic          out_valid
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [CW-1:0] count_q;
  logic is_sw, is_circ, pop_hw, pop_sw, adv_circ, start, rptr_ok, cnt_inc;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign is_hw    = (mode_q == MODE_HWQ);
  assign is_sw    = (mode_q == MODE_SWQ);
  assign is_circ  = !is_hw && !is_sw;
  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign in_ready = en_q && (is_circ || !full);
  assign push     = in_valid && in_ready;
  assign out_valid = is_hw && !empty;
  assign pop_hw   = out_valid && out_ready;
  assign pop_sw   = rd_data && is_sw && !empty;
  assign adv_circ = rd_data && is_circ && !empty;
  assign start    = wr_ctrl && !en_q && wdata[0] && !cap_stop;
  assign rptr_ok  = wr_rptr && !en_q && is_circ && (wdata < 32'(DEPTH));
  assign cnt_inc  = push && !(is_circ && full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= MODE_CIRC;
      wptr_q    <= '0;
      rptr_q    <= '0;
      count_q   <= '0;
      wrapped_q <= 1'b0;
    end else begin
      if (cap_stop)     en_q <= 1'b0;
      else if (wr_ctrl) en_q <= wdata[0];
      if (wr_ctrl && !en_q) mode_q <= wdata[2:1];

      if (start) begin
        wptr_q    <= '0;
        rptr_q    <= '0;
        count_q   <= '0;
        wrapped_q <= 1'b0;
      end else begin
        if (push) begin
          wptr_q <= nxt(wptr_q);
          if (is_circ && wptr_q == LAST) wrapped_q <= 1'b1;
        end
        if (pop_hw || pop_sw || adv_circ) rptr_q <= nxt(rptr_q);
        else if (rptr_ok)                 rptr_q <= wdata[AW-1:0];
        count_q <= count_q + CW'(cnt_inc) - CW'(pop_hw || pop_sw);
      end
    end
  end

  // R1: the write index returns to zero after the last slot
  p_wptr_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push && wptr_q == LAST && !wr_ctrl |=> wptr_q == '0);
  // R1: enabled circular capture is never stalled
  p_circ_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && is_circ |-> in_ready);
  // R2: wrapped flag is sticky during a capture
  p_wrap_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && wrapped_q |=> wrapped_q);
  // R3: occupancy never exceeds depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  // R3: full queue refuses input
  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_circ && full |-> !push);
  // R4: presented word held while the consumer stalls
  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !wr_ctrl |=> out_valid && $stable(rptr_q));
  // R6: empty read leaves the read index alone
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && empty |=> $stable(rptr_q));
  // R8: mode frozen while capture is enabled
  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(mode_q));
  // R9: stop ends capture on the next cycle
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stop |=> !en_q);
endmodule

// File: rtl/trc_regs.sv
module trc_regs
  import trc_capture_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned EW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [4:0]    paddr,
  output logic [31:0]   prdata,
  output logic          wr_ctrl,
  output logic          wr_rptr,
  output logic          rd_data,
  input  logic          en_q,
  input  logic [1:0]    mode_q,
  input  logic          wrapped_q,
  input  logic          empty,
  input  logic          full,
  input  logic          is_hw,
  input  logic [AW-1:0] wptr_q,
  input  logic [AW-1:0] rptr_q,
  input  logic [EW-1:0] mem_rd
);
  logic       hit, acc_wr, acc_rd;
  logic [2:0] idx;

  assign idx    = paddr[4:2];
  assign hit    = (paddr[1:0] == 2'b00);
  assign acc_wr = psel && penable && pwrite && hit;
  assign acc_rd = psel && penable && !pwrite && hit;

  assign wr_ctrl = acc_wr && (idx == 3'(REG_CTRL));
  assign wr_rptr = acc_wr && (idx == 3'(REG_RPTR));
  assign rd_data = acc_rd && (idx == 3'(REG_DATA));

  always_comb begin
    prdata = '0;
    if (hit) begin
      unique case (idx)
        3'(REG_CTRL):   prdata = {29'd0, mode_q, en_q};
        3'(REG_STATUS): prdata = {29'd0, wrapped_q, full, empty};
        3'(REG_WPTR):   prdata = 32'(wptr_q);
        3'(REG_RPTR):   prdata = 32'(rptr_q);
        3'(REG_DATA):   prdata = (is_hw || empty) ? '1 : 32'(mem_rd);
        default:        prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/trc_capture_buf.sv
module trc_capture_buf #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SRC_W  = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned EW    = DATA_W + SRC_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SRC_W-1:0]  in_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SRC_W-1:0]  out_src,
  input  logic              cap_stop,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [4:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata
);
  logic          en_q, wrapped_q, empty, full, is_hw, push;
  logic          wr_ctrl, wr_rptr, rd_data;
  logic [1:0]    mode_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [EW-1:0] mem_rd;

  trc_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .cap_stop(cap_stop), .wr_ctrl(wr_ctrl), .wr_rptr(wr_rptr), .rd_data(rd_data),
    .wdata(pwdata), .en_q(en_q), .mode_q(mode_q), .wptr_q(wptr_q), .rptr_q(rptr_q),
    .wrapped_q(wrapped_q), .empty(empty), .full(full), .is_hw(is_hw),
    .in_ready(in_ready), .push(push), .out_valid(out_valid)
  );

  trc_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .we(push), .waddr(wptr_q), .wdata({in_src, in_data}),
    .raddr(rptr_q), .rdata(mem_rd)
  );

  trc_regs #(.DEPTH(DEPTH), .EW(EW)) u_regs (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .prdata(prdata), .wr_ctrl(wr_ctrl), .wr_rptr(wr_rptr), .rd_data(rd_data),
    .en_q(en_q), .mode_q(mode_q), .wrapped_q(wrapped_q), .empty(empty),
    .full(full), .is_hw(is_hw), .wptr_q(wptr_q), .rptr_q(rptr_q), .mem_rd(mem_rd)
  );

  assign out_data = mem_rd[DATA_W-1:0];
  assign out_src  = mem_rd[EW-1:DATA_W];
endmodule

// File: tb/test_trc_capture_buf.sv
module test_trc_capture_buf;
  localparam int DW = 24;
  localparam int SW = 8;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, cap_stop = 0;
  logic [DW-1:0] in_data = '0, out_data;
  logic [SW-1:0] in_src = '0, out_src;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;

  int checks = 0, errors = 0;
  bit sb_on = 0, done = 0;
  logic [31:0] exp_q[$];

  always #5 clk = ~clk;

  trc_capture_buf #(.DATA_W(DW), .SRC_W(SW), .DEPTH(DEPTH)) i_trc_capture_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_src(in_src), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_src(out_src), .cap_stop(cap_stop), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end one time unit after a rising edge.
  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1 penable = 1;
    @(negedge clk); d = prdata;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic push(input logic [SW-1:0] s, input logic [DW-1:0] d,
                      input logic stop, input bit retry, output bit acc);
    in_valid = 1; in_src = s; in_data = d; cap_stop = stop;
    @(negedge clk); acc = in_ready;
    while (!acc && retry) begin @(negedge clk); acc = in_ready; end
    if (acc && sb_on) exp_q.push_back({s, d});
    @(posedge clk); #1 in_valid = 0; cap_stop = 0;
  endtask

  // Scoreboard monitor for downstream transfers (R4, R7)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 actual=%h expected=<none>", {out_src, out_data});
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if ({out_src, out_data} !== e) begin
          errors++;
          $display("FAIL R4 actual=%h expected=%h", {out_src, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, held;
    bit acc;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R12 reset state, R11 disabled
    @(negedge clk);
    chk("R11 in_ready reset", in_ready, 0);
    chk("R4 out_valid reset", out_valid, 0);
    @(posedge clk); #1;
    apb_rd(5'h00, r); chk("R12 CTRL reset", r, 0);
    apb_rd(5'h04, r); chk("R12 STATUS reset", r, 1);
    apb_rd(5'h14, r); chk("R12 unmapped", r, 0);

    // R8: software queue mode, then attempted mode change while enabled
    apb_wr(5'h00, 32'h5);
    apb_rd(5'h00, r); chk("R8 CTRL sw enabled", r, 5);
    apb_wr(5'h00, 32'h3);
    apb_rd(5'h00, r); chk("R8 mode write ignored", r, 5);

    // R5, R7: software pops
    sb_on = 1;
    push(8'hA1, 24'h000111, 0, 1, acc);
    push(8'hB2, 24'h000222, 0, 1, acc);
    push(8'hC3, 24'h000333, 0, 1, acc);
    for (int i = 0; i < 3; i++) begin
      apb_rd(5'h10, r); chk("R5 R7 sw pop", r, exp_q.pop_front());
    end
    apb_rd(5'h0C, r); chk("R5 RPTR after pops", r, 3);
    // R6: empty read
    apb_rd(5'h10, r); chk("R6 empty read", r, 32'hFFFF_FFFF);
    apb_rd(5'h0C, r); chk("R6 RPTR unchanged", r, 3);

    // R3: fill to full, no overwrite
    for (int i = 0; i < DEPTH; i++) push(8'(i + 16), 24'(i * 7 + 5), 0, 1, acc);
    push(8'hEE, 24'hBADBAD, 0, 0, acc);
    chk("R3 refused when full", 32'(acc), 0);
    apb_rd(5'h04, r); chk("R3 STATUS full", r, 2);
    apb_rd(5'h08, r); chk("R3 WPTR", r, 3);
    for (int i = 0; i < DEPTH; i++) begin
      apb_rd(5'h10, r); chk("R3 R5 drain order", r, exp_q.pop_front());
    end
    apb_rd(5'h04, r); chk("R5 STATUS empty", r, 1);

    // R11: disabled refuses input
    apb_wr(5'h00, 32'h4);
    @(negedge clk); chk("R11 disabled in_ready", in_ready, 0);
    @(posedge clk); #1;

    // R4: hardware queue mode
    apb_wr(5'h00, 32'h3);
    for (int i = 0; i < 4; i++) push(8'(i + 64), 24'(i + 24'h400), 0, 1, acc);
    @(negedge clk);
    chk("R4 out_valid", out_valid, 1);
    held = {out_src, out_data};
    chk("R4 R7 head word", held, exp_q[0]);
    repeat (3) @(negedge clk);
    chk("R4 held while stalled", {out_src, out_data}, held);
    @(posedge clk); #1;
    apb_rd(5'h10, r); chk("R6 data read in hw mode", r, 32'hFFFF_FFFF);
    out_ready = 1;
    for (int i = 0; i < 12; i++) push(8'(i + 80), 24'(i * 3 + 24'h900), 0, 1, acc);
    repeat (30) @(posedge clk);
    #1 out_ready = 0;
    @(negedge clk);
    chk("R4 queue drained", 32'(exp_q.size()), 0);
    chk("R4 out_valid empty", out_valid, 0);
    @(posedge clk); #1;
    sb_on = 0;

    // R10, R1, R2, R9: circular capture
    apb_wr(5'h00, 32'h0);
    apb_wr(5'h00, 32'h1);
    apb_rd(5'h08, r); chk("R10 WPTR cleared", r, 0);
    apb_rd(5'h04, r); chk("R10 STATUS cleared", r, 1);
    for (int i = 0; i < 15; i++) begin
      push(8'(i + 32), 24'(i + 24'h100), 0, 0, acc);
      chk("R1 circ never stalls", 32'(acc), 1);
    end
    apb_rd(5'h04, r); chk("R2 not wrapped yet", r, 0);
    push(8'(15 + 32), 24'(15 + 24'h100), 0, 0, acc);
    apb_rd(5'h04, r); chk("R2 wrapped set", r, 6);
    apb_rd(5'h08, r); chk("R1 WPTR wrapped to 0", r, 0);
    for (int i = 16; i < 20; i++) begin
      push(8'(i + 32), 24'(i + 24'h100), (i == 19), 0, acc);
      chk("R1 circ never stalls", 32'(acc), 1);
    end
    @(negedge clk); chk("R9 in_ready after stop", in_ready, 0);
    @(posedge clk); #1;
    apb_rd(5'h00, r); chk("R9 CTRL disabled", r, 0);
    apb_rd(5'h08, r); chk("R9 last word stored", r, 4);
    apb_rd(5'h04, r); chk("R2 wrapped sticky", r, 6);
    apb_wr(5'h0C, 32'd4);
    apb_rd(5'h0C, r); chk("R2 RPTR set", r, 4);
    for (int j = 0; j < DEPTH; j++) begin
      apb_rd(5'h10, r);
      chk("R1 R2 oldest first", r, {8'(j + 4 + 32), 24'(j + 4 + 24'h100)});
    end
    apb_rd(5'h0C, r); chk("R2 RPTR wrapped", r, 4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule